// File: doc/BRIEF.md
# Time-Shared Two-Group Multiply-Accumulate Element

This element sits in a systolic convolution array. It holds one multiply-add unit that runs on a fast clock at twice the rate of the surrounding fabric clock. During each fabric cycle the unit serves two kernel groups in turn. A column of such elements therefore yields partial sums for two kernel groups, so an array of n columns covers 2n groups. On every fabric cycle the element takes one activation and one incoming partial sum per group from its neighbour. For each group it forms activation × weight + incoming sum and passes both results down the cascade.

Weights sit in two banks. Each bank holds one weight per group. One bank feeds the multiplier while the other is rewritten through a load port. A swap request flips the roles on a fabric clock edge, so loading overlaps computation. The fast clock is phase-aligned to the fabric clock: every fabric rising edge coincides with a fast rising edge. The element derives its phase internally from the two clocks.

Top module: `dpmac_element`

## Requirements
- R1: While `rst_n` is low at a fabric edge, both partial-sum outputs are cleared to zero, `out_vld` is cleared, the active bank becomes bank 0 and all stored weights become zero.
- R2: `psum0_out` equals `act_in` × (active group-0 weight) + `psum0_in`, for the inputs sampled three fabric edges earlier. Results are visible after the third edge.
- R3: `psum1_out` equals `act_in` × (active group-1 weight) + `psum1_in`, with the same timing as R2.
- R4: `out_vld` reproduces `act_vld` delayed by three fabric edges. Data outputs update every cycle whatever `act_vld` is.
- R5: A weight load writes the inactive bank. `wt_ld_grp` = 0 selects the group-0 weight and 1 selects the group-1 weight. Without a swap, a load has no effect on any output.
- R6: A swap sampled at a fabric edge already applies to the activation sampled at that same edge. A load in the same cycle as a swap writes the bank that becomes active, so the loaded weight is used at once.
- R7: Both fast-clock phases of one fabric cycle use the same weight bank. A swap never splits the two groups of one sample between banks.
- R8: The fast phases alternate. The fast edge in the middle of a fabric cycle serves group 0. The fast edge that coincides with the next fabric edge serves group 1. Each group's result register changes only on its own phase.
- R9: Arithmetic is 48-bit two's complement with no saturation. A sum past the positive or negative limit wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Fabric clock |
| clk_fast | input | 1 | Arithmetic clock, twice the fabric rate, rising edges aligned |
| rst_n | input | 1 | Synchronous active-low reset, used by both clocks |
| act_in | input | 16 | Signed activation |
| act_vld | input | 1 | Activation valid, carried to `out_vld` |
| psum0_in | input | 48 | Signed incoming partial sum, group 0 |
| psum1_in | input | 48 | Signed incoming partial sum, group 1 |
| wt_ld_en | input | 1 | Write a weight into the inactive bank |
| wt_ld_grp | input | 1 | Group of the weight being written (0 or 1) |
| wt_ld_data | input | 16 | Signed weight value to write |
| wt_swap | input | 1 | Exchange the active and inactive banks |
| psum0_out | output | 48 | Cascaded partial sum, group 0 |
| psum1_out | output | 48 | Cascaded partial sum, group 1 |
| out_vld | output | 1 | Valid flag aligned with the two outputs |

## Verification
The hardest situations to reach from the ports are a swap that lands in the same cycle as a weight write, and a shadow write that must leave results untouched. The second case is visible only in how later samples behave. The bench reaches both by reloading the shadow bank in the middle of an activation sweep. It also changes banks on the cycle where the second weight of a new pair is written, and uses different weights and incoming sums for the two groups, so that a phase or bank mix-up shows in the wrong output. Extreme activation, weight and incoming-sum values drive the 48-bit sum past both limits.

// File: rtl/dpmac_pkg.sv
// Shared constants and types for the time-shared MAC element.
// Assumes exactly two kernel groups and two weight banks per element.
package dpmac_pkg;
    localparam int ACT_W_DEF = 16;
    localparam int WT_W_DEF  = 16;
    localparam int ACC_W_DEF = 48;
    localparam int NUM_GRP   = 2;
    localparam int NUM_BANK  = 2;

    typedef enum logic {
        GRP_ZERO = 1'b0,
        GRP_ONE  = 1'b1
    } grp_sel_e;
endpackage

// File: rtl/dpmac_phase.sv
// Phase detector for the fast clock.
// A toggle in the fabric domain is sampled in the fast domain. Equal values
// mark the fast edge aligned with a fabric edge, which serves group 1. The
// mid-cycle edge serves group 0.
// Assumes clk_fast runs at exactly 2x clk_slow with aligned rising edges.
module dpmac_phase (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic rst_n,
    output logic serve_g1
);
    logic tgl_s;
    logic tgl_f;

    // Fabric-domain toggle, flips once per fabric cycle.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) tgl_s <= 1'b0;
        else        tgl_s <= ~tgl_s;
    end

    // Fast-domain copy of the toggle, one fast edge behind.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) tgl_f <= 1'b0;
        else        tgl_f <= tgl_s;
    end

    assign serve_g1 = ~(tgl_s ^ tgl_f);

    AST_PHASE_ALT_HI: assert property (@(posedge clk_fast) disable iff (!rst_n)
        serve_g1 |=> !serve_g1);  // R8
    AST_PHASE_ALT_LO: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !serve_g1 |=> serve_g1);  // R8
endmodule

// File: rtl/dpmac_wbank.sv
// Two weight banks, each with one weight per kernel group.
// Loads go to the inactive bank. A swap flips the active bank on a fabric
// edge. A load and a swap in the same cycle write the bank about to become
// active. Assumes the fast domain reads the outputs only between fabric edges.
module dpmac_wbank #(
    parameter int WT_W = dpmac_pkg::WT_W_DEF
) (
    input  logic                    clk_slow,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  dpmac_pkg::grp_sel_e     ld_grp,
    input  logic [WT_W-1:0]         ld_data,
    input  logic                    swap,
    output logic                    bank_sel,
    output logic [WT_W-1:0]         w_g0,
    output logic [WT_W-1:0]         w_g1
);
    import dpmac_pkg::*;

    logic [WT_W-1:0] wmem [NUM_BANK][NUM_GRP];

    // Bank storage, shadow write and active-bank flip.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;
            for (int b = 0; b < NUM_BANK; b++)
                for (int g = 0; g < NUM_GRP; g++)
                    wmem[b][g] <= '0;
        end else begin
            if (ld_en) wmem[~bank_sel][ld_grp] <= ld_data;
            if (swap)  bank_sel <= ~bank_sel;
        end
    end

    assign w_g0 = wmem[bank_sel][GRP_ZERO];
    assign w_g1 = wmem[bank_sel][GRP_ONE];

    AST_SHADOW_ONLY: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (ld_en && !swap) |=> ($stable(w_g0) && $stable(w_g1)));  // R5
    AST_SWAP_FLIPS: assert property (@(posedge clk_slow) disable iff (!rst_n)
        swap |=> (bank_sel != $past(bank_sel)));  // R6
endmodule

// File: rtl/dpmac_core.sv
// Fast-clock multiply-add shared by two kernel groups.
// Operand multiplexers pick the weight and incoming sum of the group that
// the phase selects. Group 0 is computed mid-cycle and copied into a holding
// register at the following aligned edge, where group 1 is computed. Both
// results then stay stable for a full fabric cycle.
// Assumes the operands change only on fabric edges. Sums wrap, no saturation.
module dpmac_core #(
    parameter int ACT_W = dpmac_pkg::ACT_W_DEF,
    parameter int WT_W  = dpmac_pkg::WT_W_DEF,
    parameter int ACC_W = dpmac_pkg::ACC_W_DEF
) (
    input  logic                    clk_fast,
    input  logic                    rst_n,
    input  logic                    serve_g1,
    input  logic signed [ACT_W-1:0] act,
    input  logic signed [WT_W-1:0]  w_g0,
    input  logic signed [WT_W-1:0]  w_g1,
    input  logic signed [ACC_W-1:0] pin_g0,
    input  logic signed [ACC_W-1:0] pin_g1,
    output logic signed [ACC_W-1:0] hold_g0,
    output logic signed [ACC_W-1:0] res_g1
);
    localparam int PROD_W = ACT_W + WT_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [WT_W-1:0]   w_op;
    logic signed [ACC_W-1:0]  p_op;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  res_g0;

    // Operand selection and the shared multiply-add.
    always_comb begin
        w_op = serve_g1 ? w_g1 : w_g0;
        p_op = serve_g1 ? pin_g1 : pin_g0;
        prod = act * w_op;
        sum  = {{EXT_W{prod[PROD_W-1]}}, prod} + p_op;
    end

    // Per-phase result capture and group-0 hold.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            res_g0  <= '0;
            res_g1  <= '0;
            hold_g0 <= '0;
        end else if (serve_g1) begin
            res_g1  <= sum;
            hold_g0 <= res_g0;
        end else begin
            res_g0  <= sum;
        end
    end

    AST_G0_OWN_PHASE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        serve_g1 |=> $stable(res_g0));  // R8
    AST_G1_OWN_PHASE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !serve_g1 |=> $stable(res_g1));  // R8
endmodule

// File: rtl/dpmac_element.sv
// Time-shared two-group MAC element for a systolic convolution array.
// It registers the activation, the incoming sums and the valid flag on the
// fabric clock, runs the shared multiply-add on the 2x clock, and re-registers
// both group results into the fabric domain with a matching valid flag.
// Latency is three fabric edges from input to output.
module dpmac_element #(
    parameter int ACT_W = dpmac_pkg::ACT_W_DEF,
    parameter int WT_W  = dpmac_pkg::WT_W_DEF,
    parameter int ACC_W = dpmac_pkg::ACC_W_DEF
) (
    input  logic                    clk_slow,
    input  logic                    clk_fast,
    input  logic                    rst_n,
    input  logic [ACT_W-1:0]        act_in,
    input  logic                    act_vld,
    input  logic [ACC_W-1:0]        psum0_in,
    input  logic [ACC_W-1:0]        psum1_in,
    input  logic                    wt_ld_en,
    input  logic                    wt_ld_grp,
    input  logic [WT_W-1:0]         wt_ld_data,
    input  logic                    wt_swap,
    output logic [ACC_W-1:0]        psum0_out,
    output logic [ACC_W-1:0]        psum1_out,
    output logic                    out_vld
);
    import dpmac_pkg::*;

    logic signed [ACT_W-1:0] act_q;
    logic signed [ACC_W-1:0] pin0_q;
    logic signed [ACC_W-1:0] pin1_q;
    logic                    vld_q1;
    logic                    vld_q2;
    logic                    serve_g1;
    logic                    bank_sel;
    logic [WT_W-1:0]         w_g0;
    logic [WT_W-1:0]         w_g1;
    logic signed [ACC_W-1:0] hold_g0;
    logic signed [ACC_W-1:0] res_g1;
    grp_sel_e                ld_grp;

    assign ld_grp = grp_sel_e'(wt_ld_grp);

    // Input capture into the fabric domain.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            act_q  <= '0;
            pin0_q <= '0;
            pin1_q <= '0;
            vld_q1 <= 1'b0;
            vld_q2 <= 1'b0;
        end else begin
            act_q  <= act_in;
            pin0_q <= psum0_in;
            pin1_q <= psum1_in;
            vld_q1 <= act_vld;
            vld_q2 <= vld_q1;
        end
    end

    dpmac_phase u_phase (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .serve_g1 (serve_g1)
    );

    dpmac_wbank #(.WT_W(WT_W)) u_wbank (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .ld_en    (wt_ld_en),
        .ld_grp   (ld_grp),
        .ld_data  (wt_ld_data),
        .swap     (wt_swap),
        .bank_sel (bank_sel),
        .w_g0     (w_g0),
        .w_g1     (w_g1)
    );

    dpmac_core #(.ACT_W(ACT_W), .WT_W(WT_W), .ACC_W(ACC_W)) u_core (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .serve_g1 (serve_g1),
        .act      (act_q),
        .w_g0     (w_g0),
        .w_g1     (w_g1),
        .pin_g0   (pin0_q),
        .pin_g1   (pin1_q),
        .hold_g0  (hold_g0),
        .res_g1   (res_g1)
    );

    // Re-registration of both group results into the fabric domain.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            psum0_out <= '0;
            psum1_out <= '0;
            out_vld   <= 1'b0;
        end else begin
            psum0_out <= hold_g0;
            psum1_out <= res_g1;
            out_vld   <= vld_q2;
        end
    end

    AST_BANK_STEADY: assert property (@(posedge clk_fast) disable iff (!rst_n)
        serve_g1 |-> $stable(bank_sel));  // R7
    AST_VLD_PIPE: assert property (@(posedge clk_slow) disable iff (!rst_n)
        out_vld |-> $past(act_vld, 3));  // R4
    AST_RESET_CLEAR: assert property (@(posedge clk_slow)
        !rst_n |=> (!out_vld && psum0_out == '0 && psum1_out == '0));  // R1
endmodule

// File: tb/sim_dpmac_element.sv
// Sweep bench: several weight pairs, each crossed with a set of activations
// and incoming sums. Expected results come from a model of the banks and a
// three-deep expectation pipeline.
module sim_dpmac_element;
    logic clk_slow, clk_fast, rst_n;
    logic signed [15:0] act_in, wt_ld_data;
    logic act_vld, wt_ld_en, wt_ld_grp, wt_swap;
    logic signed [47:0] psum0_in, psum1_in;
    logic [47:0] psum0_out, psum1_out;
    logic out_vld;

    int n_run = 0;
    int n_fail = 0;

    logic signed [15:0] mw [0:1][0:1];
    int mbank;
    logic [47:0] q0 [0:2];
    logic [47:0] q1 [0:2];
    logic        qv [0:2];
    string       t0 [0:2];
    string       t1 [0:2];

    dpmac_element u0 (
        .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
        .act_in(act_in), .act_vld(act_vld),
        .psum0_in(psum0_in), .psum1_in(psum1_in),
        .wt_ld_en(wt_ld_en), .wt_ld_grp(wt_ld_grp), .wt_ld_data(wt_ld_data),
        .wt_swap(wt_swap),
        .psum0_out(psum0_out), .psum1_out(psum1_out), .out_vld(out_vld)
    );

    // 50 MHz fabric clock with an aligned 100 MHz arithmetic clock.
    initial begin
        clk_fast = 0; clk_slow = 0;
        forever begin
            #5 clk_fast = 1; clk_slow = 1;
            #5 clk_fast = 0;
            #5 clk_fast = 1; clk_slow = 0;
            #5 clk_fast = 0;
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [15:0] act_val(input int i);
        case (i)
            0: return -16'sd32768;
            1: return -16'sd1;
            2: return 16'sd0;
            3: return 16'sd1;
            4: return 16'sd32767;
            5: return 16'sd12345;
            6: return -16'sd20000;
            default: return 16'sd256;
        endcase
    endfunction

    function automatic logic signed [15:0] wt_val(input int s, input int g);
        case (s)
            0: return g == 0 ? 16'sd3      : -16'sd5;
            1: return g == 0 ? -16'sd32768 : 16'sd32767;
            2: return g == 0 ? 16'sd32767  : 16'sd32767;
            3: return g == 0 ? -16'sd1     : 16'sd1;
            4: return g == 0 ? 16'sd0      : -16'sd32768;
            default: return g == 0 ? 16'sd1234 : -16'sd4321;
        endcase
    endfunction

    // One fabric cycle: check the oldest expectation, then drive a new sample.
    task automatic step(input logic signed [15:0] a, input logic v,
                        input logic signed [47:0] p0, input logic signed [47:0] p1,
                        input logic ld, input logic lg, input logic signed [15:0] ld_d,
                        input logic sw, input string tag0, input string tag1);
        longint e0, e1;
        @(negedge clk_slow); #2;
        chk(t0[2], psum0_out, q0[2]);
        chk(t1[2], psum1_out, q1[2]);
        chk("R4", {47'd0, out_vld}, {47'd0, qv[2]});
        for (int k = 2; k > 0; k--) begin
            q0[k] = q0[k-1]; q1[k] = q1[k-1]; qv[k] = qv[k-1];
            t0[k] = t0[k-1]; t1[k] = t1[k-1];
        end
        act_in = a; act_vld = v; psum0_in = p0; psum1_in = p1;
        wt_ld_en = ld; wt_ld_grp = lg; wt_ld_data = ld_d; wt_swap = sw;
        if (ld) mw[1 - mbank][lg] = ld_d;
        if (sw) mbank = 1 - mbank;
        e0 = longint'(a) * longint'(mw[mbank][0]) + longint'(p0);
        e1 = longint'(a) * longint'(mw[mbank][1]) + longint'(p1);
        q0[0] = e0[47:0]; q1[0] = e1[47:0]; qv[0] = v;
        t0[0] = tag0; t1[0] = tag1;
    endtask

    initial begin
        mbank = 0;
        for (int b = 0; b < 2; b++) for (int g = 0; g < 2; g++) mw[b][g] = 0;
        for (int k = 0; k < 3; k++) begin
            q0[k] = 0; q1[k] = 0; qv[k] = 0; t0[k] = "R1"; t1[k] = "R1";
        end
        // R1: reset with busy inputs.
        rst_n = 0; act_in = 16'sd77; act_vld = 1; psum0_in = 48'sd9; psum1_in = 48'sd11;
        wt_ld_en = 1; wt_ld_grp = 0; wt_ld_data = 16'sd5; wt_swap = 1;
        repeat (4) @(posedge clk_slow);
        @(negedge clk_slow); #2;
        chk("R1", psum0_out, 48'd0);
        chk("R1", psum1_out, 48'd0);
        chk("R1", {47'd0, out_vld}, 48'd0);
        act_in = 0; act_vld = 0; psum0_in = 0; psum1_in = 0;
        wt_ld_en = 0; wt_ld_data = 0; wt_swap = 0; rst_n = 1;

        // R1: weights are zero after reset, so the output is the incoming sum.
        step(16'sd100, 1, 48'sd42, -48'sd42, 0, 0, 0, 0, "R1", "R1");

        for (int s = 0; s < 6; s++) begin
            string g0tag, g1tag;
            g0tag = (s == 0) ? "R8" : "R2";
            g1tag = (s == 0) ? "R8" : "R3";
            // Shadow load of group 0, then group 1 together with the swap (R6, R7).
            step(16'sd7, 1, 48'sd1000, 48'sd2000, 1, 0, wt_val(s, 0), 0, "R5", "R5");
            step(16'sd9, 1, -48'sd5, 48'sd5, 1, 1, wt_val(s, 1), 1, "R6", "R7");
            for (int ai = 0; ai < 8; ai++) begin
                logic signed [47:0] p0, p1;
                p0 = 48'(longint'(ai) * 1000003 - 3000000);
                p1 = 48'(17 - (longint'(ai) <<< 40));
                // R5: junk written to the shadow bank mid-sweep must not show.
                if (ai == 3)
                    step(act_val(ai), 1'b1, p0, p1, 1, 0, -16'sd999, 0, "R5", "R5");
                else if (ai > 3)
                    step(act_val(ai), ai % 2 == 1, p0, p1, 0, 0, 0, 0, "R5", "R5");
                else
                    step(act_val(ai), ai % 2 == 1, p0, p1, 0, 0, 0, 0, g0tag, g1tag);
            end
        end

        // R6: swap alone returns to the other bank for the same-cycle sample.
        step(16'sd3, 1, 48'sd0, 48'sd0, 0, 0, 0, 1, "R6", "R7");
        step(16'sd3, 0, 48'sd0, 48'sd0, 0, 0, 0, 1, "R6", "R7");

        // R9: wrap past both limits with extreme weights.
        step(16'sd1, 1, 48'sd0, 48'sd0, 1, 0, 16'sd32767, 0, "R9", "R9");
        step(16'sd1, 1, 48'sd0, 48'sd0, 1, 1, -16'sd32768, 1, "R9", "R9");
        step(16'sd32767, 1, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000, 0, 0, 0, 0, "R9", "R9");
        step(-16'sd32768, 1, 48'h7FFF_FFFF_0000, 48'h8000_0000_FFFF, 0, 0, 0, 0, "R9", "R9");
        step(-16'sd1, 0, 48'h8000_0000_0000, 48'h7FFF_FFFF_FFFF, 0, 0, 0, 0, "R9", "R9");

        // Flush the pipeline.
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "R3");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule